// File: doc/BRIEF.md
# System Management Entry and Exit Sequencer

This block decides when a processor core leaves normal execution for system management mode, and it runs the entry and the later exit. Two kinds of request can start an entry. One is an active-low interrupt pin, which must stay low long enough to count. The other is a one-cycle software strobe from the instruction decoder. Three configuration inputs decide whether a request is taken: a global enable, a bit that chooses between pin and software triggering, and a 4-bit region-size field.

When a request is taken, the block captures a small context record. This holds the faulting memory address, the memory data, an I/O-versus-memory flag and a video-region flag. The block writes the record as three 32-bit words, going down from a separate header address, with a valid/ready handshake on each word. Once the last word is accepted, it raises a real-mode level and sends a one-cycle fetch redirect to the region base.

A resume strobe reads the same three words back through a matching read handshake. The block presents the restored fields and then returns to normal execution. A request that arrives while management mode is active is held. It starts a fresh entry either at once, when nesting is enabled, or after the restore completes.

Top module: `smm_entry_seq`

## Requirements
- R1: A pin request counts only after `smi_pin_n` has been sampled low on at least 2 consecutive rising clock edges. A single low sample starts no entry.
- R2: A pin request is taken only when `cfg_enable`=1, `cfg_sw_mode`=0 and `cfg_region_size`!=0. Otherwise it is discarded.
- R3: A `sw_trig` strobe is taken only when `cfg_enable`=1, `cfg_sw_mode`=1 and `cfg_region_size`!=0. Otherwise it is discarded.
- R4: On entry the header is written as 3 words, one per accepted handshake (`hdr_wr_valid` and `hdr_wr_ready` high on the same edge), with the fields placed as follows:
  - word 0 at `hdr_base` holds the captured address;
  - word 1 at `hdr_base`-4 holds the captured data;
  - word 2 at `hdr_base`-8 holds flags: bit0 = I/O access, bit1 = video region, bit2 = 1 when the pin caused the entry.

  Address and data hold steady while ready is low.
- R5: In the edge that accepts the last header word, `redirect_valid` pulses for one cycle with `redirect_addr` equal to `cfg_region_base`. From that edge, `real_mode` and `in_smm` are 1.
- R6: A request taken while management mode is active with `nest_en`=0 writes no header until the current restore completes, and then enters again. With `nest_en`=1 it starts a new header save at once.
- R7: A `resume` strobe in active management mode reads the 3 words from the same addresses in the same order through the read handshake. It loads `rest_addr`, `rest_data`, `rest_is_io` (flag bit0) and `rest_video` (flag bit1), pulses `restore_done`, and returns `in_smm` and `real_mode` to 0.
- R8: A `resume` strobe outside active management mode changes no state and pulses `resume_err` for exactly one cycle.
- R9: After reset, `in_smm`, `real_mode`, `hdr_wr_valid`, `hdr_rd_valid`, `redirect_valid`, `restore_done` and `resume_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_pin_n | input | 1 | Active-low external request pin |
| sw_trig | input | 1 | One-cycle software entry strobe |
| resume | input | 1 | One-cycle resume strobe |
| cfg_enable | input | 1 | Global enable for management entry |
| cfg_sw_mode | input | 1 | 0 selects pin triggering, 1 selects software triggering |
| cfg_region_size | input | 4 | Region size, zero disables entry |
| cfg_region_base | input | 32 | Management region base address |
| hdr_base | input | 32 | Physical address of the top header word |
| nest_en | input | 1 | Allows entry while already in management mode |
| ctx_addr | input | 32 | Memory address to capture |
| ctx_data | input | 32 | Memory data to capture |
| ctx_is_io | input | 1 | Captured access was an I/O access |
| ctx_video | input | 1 | Captured access hit the video region |
| hdr_wr_valid | output | 1 | Header write word valid |
| hdr_wr_ready | input | 1 | Header write word accepted |
| hdr_wr_addr | output | 32 | Header write address |
| hdr_wr_data | output | 32 | Header write data |
| hdr_rd_valid | output | 1 | Header read request valid |
| hdr_rd_ready | input | 1 | Header read data present this cycle |
| hdr_rd_addr | output | 32 | Header read address |
| hdr_rd_data | input | 32 | Header read data |
| in_smm | output | 1 | Block is in management mode (save, active or restore) |
| real_mode | output | 1 | Real-mode indication after the header save |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_addr | output | 32 | Fetch redirect target |
| rest_addr | output | 32 | Restored address |
| rest_data | output | 32 | Restored data |
| rest_is_io | output | 1 | Restored I/O flag |
| rest_video | output | 1 | Restored video flag |
| restore_done | output | 1 | One-cycle restore completion strobe |
| resume_err | output | 1 | One-cycle stray-resume error |

## Verification
The assertions take some things about the inputs for granted:
- the header sink accepts words in order;
- the context and configuration inputs are steady while a request is being recognised and saved;
- `resume` and `sw_trig` are single-cycle strobes.

The hold and descending-address checks depend on the first of these, and the bench keeps to all three. It drives every input on the falling edge, toggles both ready lines every cycle in the stall phase, and changes the context only while the block is idle or active. It never raises a resume in the same cycle as a nested request.

// File: rtl/smm_pkg.sv
package smm_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_SAVE    = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_RESTORE = 2'd3
    } smm_state_e;

    localparam int HDR_WORDS = 3;
    localparam int HDR_IDX_W = 2;
endpackage

// File: rtl/smm_pin_qual.sv
module smm_pin_qual #(
    parameter int PIN_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fire
);
    localparam int CW = $clog2(PIN_MIN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fire;
    } qual_t;

    qual_t q, d;

    always_comb begin
        d = q;
        if (pin_n) begin
            d.cnt = '0;
        end else if (q.cnt != CW'(PIN_MIN)) begin
            d.cnt = q.cnt + 1'b1;
        end
        d.fire = !pin_n && (q.cnt == CW'(PIN_MIN - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fire = q.fire;

    // R1
    fire_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(!pin_n));
endmodule

// File: rtl/smm_trig_gate.sv
module smm_trig_gate #(
    parameter int SIZE_W = 4
) (
    input  logic              pin_fire,
    input  logic              sw_trig,
    input  logic              cfg_enable,
    input  logic              cfg_sw_mode,
    input  logic [SIZE_W-1:0] cfg_region_size,
    output logic              take_pin,
    output logic              take_sw
);
    logic size_ok;

    always_comb begin
        size_ok  = |cfg_region_size;
        take_pin = pin_fire && cfg_enable && !cfg_sw_mode && size_ok;
        // the pin wins: a software strobe in the same cycle is dropped
        take_sw  = sw_trig && cfg_enable && cfg_sw_mode && size_ok && !take_pin;
    end
endmodule

// File: rtl/smm_entry_seq.sv
module smm_entry_seq #(
    parameter int XW      = 32,
    parameter int SIZE_W  = 4,
    parameter int PIN_MIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smi_pin_n,
    input  logic              sw_trig,
    input  logic              resume,
    input  logic              cfg_enable,
    input  logic              cfg_sw_mode,
    input  logic [SIZE_W-1:0] cfg_region_size,
    input  logic [XW-1:0]     cfg_region_base,
    input  logic [XW-1:0]     hdr_base,
    input  logic              nest_en,
    input  logic [XW-1:0]     ctx_addr,
    input  logic [XW-1:0]     ctx_data,
    input  logic              ctx_is_io,
    input  logic              ctx_video,
    output logic              hdr_wr_valid,
    input  logic              hdr_wr_ready,
    output logic [XW-1:0]     hdr_wr_addr,
    output logic [XW-1:0]     hdr_wr_data,
    output logic              hdr_rd_valid,
    input  logic              hdr_rd_ready,
    output logic [XW-1:0]     hdr_rd_addr,
    input  logic [XW-1:0]     hdr_rd_data,
    output logic              in_smm,
    output logic              real_mode,
    output logic              redirect_valid,
    output logic [XW-1:0]     redirect_addr,
    output logic [XW-1:0]     rest_addr,
    output logic [XW-1:0]     rest_data,
    output logic              rest_is_io,
    output logic              rest_video,
    output logic              restore_done,
    output logic              resume_err
);
    import smm_pkg::*;

    localparam logic [HDR_IDX_W-1:0] LAST_IDX = HDR_IDX_W'(HDR_WORDS - 1);

    typedef struct packed {
        smm_state_e           state;
        logic [HDR_IDX_W-1:0] idx;
        logic                 pend;
        logic                 pend_pin;
        logic [XW-1:0]        snap_addr;
        logic [XW-1:0]        snap_data;
        logic                 snap_io;
        logic                 snap_vid;
        logic                 snap_pin;
        logic                 redir;
        logic [XW-1:0]        redir_addr;
        logic                 err;
        logic [XW-1:0]        r_addr;
        logic [XW-1:0]        r_data;
        logic                 r_io;
        logic                 r_vid;
        logic                 r_done;
    } seq_t;

    seq_t q, d;
    logic pin_fire, take_pin, take_sw;
    logic [XW-1:0] hdr_off;
    logic wr_fire, rd_fire;

    smm_pin_qual #(.PIN_MIN(PIN_MIN)) u_pin_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (smi_pin_n),
        .fire  (pin_fire)
    );

    smm_trig_gate #(.SIZE_W(SIZE_W)) u_trig_gate (
        .pin_fire        (pin_fire),
        .sw_trig         (sw_trig),
        .cfg_enable      (cfg_enable),
        .cfg_sw_mode     (cfg_sw_mode),
        .cfg_region_size (cfg_region_size),
        .take_pin        (take_pin),
        .take_sw         (take_sw)
    );

    always_comb begin
        hdr_off      = {{(XW-HDR_IDX_W-2){1'b0}}, q.idx, 2'b00};
        hdr_wr_valid = (q.state == ST_SAVE);
        hdr_rd_valid = (q.state == ST_RESTORE);
        hdr_wr_addr  = hdr_base - hdr_off;
        hdr_rd_addr  = hdr_base - hdr_off;
        case (q.idx)
            2'd0:    hdr_wr_data = q.snap_addr;
            2'd1:    hdr_wr_data = q.snap_data;
            default: hdr_wr_data = XW'({q.snap_pin, q.snap_vid, q.snap_io});
        endcase
        wr_fire = hdr_wr_valid && hdr_wr_ready;
        rd_fire = hdr_rd_valid && hdr_rd_ready;
    end

    always_comb begin
        d        = q;
        d.redir  = 1'b0;
        d.err    = 1'b0;
        d.r_done = 1'b0;

        if (!q.pend && (take_pin || take_sw)) begin
            d.pend     = 1'b1;
            d.pend_pin = take_pin;
        end

        case (q.state)
            ST_NORMAL: begin
                if (q.pend) begin
                    d.state     = ST_SAVE;
                    d.idx       = '0;
                    d.pend      = 1'b0;
                    d.snap_addr = ctx_addr;
                    d.snap_data = ctx_data;
                    d.snap_io   = ctx_is_io;
                    d.snap_vid  = ctx_video;
                    d.snap_pin  = q.pend_pin;
                end
            end
            ST_SAVE: begin
                if (wr_fire) begin
                    if (q.idx == LAST_IDX) begin
                        d.state      = ST_ACTIVE;
                        d.idx        = '0;
                        d.redir      = 1'b1;
                        d.redir_addr = cfg_region_base;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_ACTIVE: begin
                if (resume) begin
                    d.state = ST_RESTORE;
                    d.idx   = '0;
                end else if (q.pend && nest_en) begin
                    d.state     = ST_SAVE;
                    d.idx       = '0;
                    d.pend      = 1'b0;
                    d.snap_addr = ctx_addr;
                    d.snap_data = ctx_data;
                    d.snap_io   = ctx_is_io;
                    d.snap_vid  = ctx_video;
                    d.snap_pin  = q.pend_pin;
                end
            end
            default: begin
                if (rd_fire) begin
                    case (q.idx)
                        2'd0: d.r_addr = hdr_rd_data;
                        2'd1: d.r_data = hdr_rd_data;
                        default: begin
                            d.r_io  = hdr_rd_data[0];
                            d.r_vid = hdr_rd_data[1];
                        end
                    endcase
                    if (q.idx == LAST_IDX) begin
                        d.state  = ST_NORMAL;
                        d.idx    = '0;
                        d.r_done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
        endcase

        if (resume && q.state != ST_ACTIVE) d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_NORMAL, default: '0};
        else        q <= d;
    end

    assign in_smm         = (q.state != ST_NORMAL);
    assign real_mode      = (q.state == ST_ACTIVE) || (q.state == ST_RESTORE);
    assign redirect_valid = q.redir;
    assign redirect_addr  = q.redir_addr;
    assign rest_addr      = q.r_addr;
    assign rest_data      = q.r_data;
    assign rest_is_io     = q.r_io;
    assign rest_video     = q.r_vid;
    assign restore_done   = q.r_done;
    assign resume_err     = q.err;

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_wr_valid && !hdr_wr_ready) |=>
            (hdr_wr_valid && $stable(hdr_wr_addr) && $stable(hdr_wr_data)));

    // R4
    wr_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_wr_valid && hdr_wr_ready) |=>
            (!hdr_wr_valid || hdr_wr_addr == $past(hdr_wr_addr) - XW'(4)));

    // R5
    redir_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> ($past(hdr_wr_valid && hdr_wr_ready) && real_mode));

    // R7
    restore_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_done |-> ($past(hdr_rd_valid && hdr_rd_ready) && !in_smm));

    // R8
    stray_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_err |-> ($past(resume) && !$past(real_mode && !hdr_rd_valid)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_smm |-> (!real_mode && !hdr_wr_valid && !hdr_rd_valid));
endmodule

// File: tb/tb_smm_entry_seq.sv
`timescale 1ns/1ps
module tb_smm_entry_seq;
    localparam logic [31:0] BASE = 32'h000A_0000;
    localparam logic [31:0] HB   = 32'h000A_FFFC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smi_pin_n = 1'b1, sw_trig = 1'b0, resume = 1'b0;
    logic cfg_enable = 1'b1, cfg_sw_mode = 1'b0;
    logic [3:0] cfg_region_size = 4'd4;
    logic [31:0] cfg_region_base = BASE, hdr_base = HB;
    logic nest_en = 1'b0;
    logic [31:0] ctx_addr = '0, ctx_data = '0;
    logic ctx_is_io = 1'b0, ctx_video = 1'b0;
    logic hdr_wr_valid, hdr_rd_valid, hdr_wr_ready, hdr_rd_ready;
    logic [31:0] hdr_wr_addr, hdr_wr_data, hdr_rd_addr, hdr_rd_data;
    logic in_smm, real_mode, redirect_valid, restore_done, resume_err;
    logic [31:0] redirect_addr, rest_addr, rest_data;
    logic rest_is_io, rest_video;

    logic stall = 1'b0;
    logic [31:0] tweak = '0;
    logic [31:0] mem [3];
    int wr_cnt = 0, order_err = 0, redir_cnt = 0, rest_cnt = 0, err_cnt = 0;
    logic [31:0] redir_seen = '0;
    int checks = 0, failures = 0, cyc = 0;

    always #2 clk = ~clk;

    smm_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .smi_pin_n(smi_pin_n), .sw_trig(sw_trig),
        .resume(resume), .cfg_enable(cfg_enable), .cfg_sw_mode(cfg_sw_mode),
        .cfg_region_size(cfg_region_size), .cfg_region_base(cfg_region_base),
        .hdr_base(hdr_base), .nest_en(nest_en), .ctx_addr(ctx_addr),
        .ctx_data(ctx_data), .ctx_is_io(ctx_is_io), .ctx_video(ctx_video),
        .hdr_wr_valid(hdr_wr_valid), .hdr_wr_ready(hdr_wr_ready),
        .hdr_wr_addr(hdr_wr_addr), .hdr_wr_data(hdr_wr_data),
        .hdr_rd_valid(hdr_rd_valid), .hdr_rd_ready(hdr_rd_ready),
        .hdr_rd_addr(hdr_rd_addr), .hdr_rd_data(hdr_rd_data),
        .in_smm(in_smm), .real_mode(real_mode), .redirect_valid(redirect_valid),
        .redirect_addr(redirect_addr), .rest_addr(rest_addr), .rest_data(rest_data),
        .rest_is_io(rest_is_io), .rest_video(rest_video),
        .restore_done(restore_done), .resume_err(resume_err)
    );

    // header sink and source: ready toggles when stall is set
    always @(negedge clk) begin
        if (stall) begin
            hdr_wr_ready <= ~hdr_wr_ready;
            hdr_rd_ready <= ~hdr_rd_ready;
        end else begin
            hdr_wr_ready <= 1'b1;
            hdr_rd_ready <= 1'b1;
        end
    end

    always_comb begin
        logic [31:0] off;
        off = HB - hdr_rd_addr;
        hdr_rd_data = (off <= 32'd8) ? (mem[off[3:2]] ^ tweak) : 32'hDEAD_BEEF;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (hdr_wr_valid && hdr_wr_ready) begin
            logic [31:0] off;
            off = HB - hdr_wr_addr;
            if (off > 32'd8 || int'(off[3:2]) != (wr_cnt % 3)) order_err <= order_err + 1;
            else mem[off[3:2]] <= hdr_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (redirect_valid) begin
            redir_cnt  <= redir_cnt + 1;
            redir_seen <= redirect_addr;
        end
        if (restore_done) rest_cnt <= rest_cnt + 1;
        if (resume_err) err_cnt <= err_cnt + 1;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_redir(input int target);
        for (int i = 0; i < 60 && redir_cnt < target; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_sw();
        @(negedge clk) sw_trig = 1'b1;
        @(negedge clk) sw_trig = 1'b0;
    endtask

    task automatic pin_low(input int n);
        @(negedge clk) smi_pin_n = 1'b0;
        idle(n);
        smi_pin_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R9", "in_smm", 32'(in_smm), 0);
        check("R9", "real_mode", 32'(real_mode), 0);
        check("R9", "valids", 32'({hdr_wr_valid, hdr_rd_valid, redirect_valid}), 0);
        check("R9", "pulses", 32'({restore_done, resume_err}), 0);
    endtask

    task automatic t_stray_resume();
        @(negedge clk) resume = 1'b1;
        @(negedge clk) resume = 1'b0;
        check("R8", "err pulse", 32'(resume_err), 1);
        @(negedge clk);
        check("R8", "err width", 32'(resume_err), 0);
        check("R8", "no entry", 32'(in_smm), 0);
        check("R8", "no reads", 32'(rest_cnt), 0);
    endtask

    task automatic t_pin_glitch();
        pin_low(1);
        idle(10);
        check("R1", "glitch entry", 32'(in_smm), 0);
        check("R1", "glitch writes", 32'(wr_cnt), 0);
    endtask

    task automatic t_pin_gated();
        cfg_enable = 1'b0;
        pin_low(4); idle(8);
        check("R2", "disabled", 32'(wr_cnt), 0);
        cfg_enable = 1'b1; cfg_sw_mode = 1'b1;
        pin_low(4); idle(8);
        check("R2", "sw mode", 32'(wr_cnt), 0);
        cfg_sw_mode = 1'b0; cfg_region_size = 4'd0;
        pin_low(4); idle(8);
        check("R2", "size zero", 32'(wr_cnt), 0);
        check("R2", "idle", 32'(in_smm), 0);
        cfg_region_size = 4'd4;
    endtask

    task automatic t_pin_entry();
        ctx_addr = 32'h1234_5678; ctx_data = 32'h9ABC_DEF0;
        ctx_is_io = 1'b1; ctx_video = 1'b0;
        stall = 1'b1;
        pin_low(2);
        wait_redir(1);
        stall = 1'b0;
        check("R4", "word count", 32'(wr_cnt), 3);
        check("R4", "order", 32'(order_err), 0);
        check("R4", "word0 addr", mem[0], 32'h1234_5678);
        check("R4", "word1 data", mem[1], 32'h9ABC_DEF0);
        check("R4", "word2 flags", mem[2], 32'h5);
        check("R5", "redirect", redir_seen, BASE);
        check("R5", "real_mode", 32'(real_mode), 1);
        check("R5", "in_smm", 32'(in_smm), 1);
    endtask

    task automatic t_pending_resume();
        cfg_sw_mode = 1'b1;
        ctx_addr = 32'h0000_4444; ctx_data = 32'h5555_0000;
        ctx_is_io = 1'b0; ctx_video = 1'b1;
        pulse_sw();
        idle(10);
        check("R6", "held writes", 32'(wr_cnt), 3);
        check("R6", "still active", 32'(real_mode), 1);
        tweak = 32'h0000_0F0F;
        @(negedge clk) resume = 1'b1;
        @(negedge clk) resume = 1'b0;
        for (int i = 0; i < 20 && rest_cnt < 1; i++) @(negedge clk);
        check("R7", "restore count", 32'(rest_cnt), 1);
        check("R7", "rest_addr", rest_addr, 32'h1234_5678 ^ 32'h0000_0F0F);
        check("R7", "rest_data", rest_data, 32'h9ABC_DEF0 ^ 32'h0000_0F0F);
        check("R7", "rest flags", 32'({rest_video, rest_is_io}), 32'b10);
        tweak = '0;
        wait_redir(2);
        check("R6", "deferred entry", 32'(wr_cnt), 6);
        check("R6", "sw flags", mem[2], 32'h2);
        check("R6", "deferred addr", mem[0], 32'h0000_4444);
        check("R8", "no stray err", 32'(err_cnt), 1);
    endtask

    task automatic t_nest();
        nest_en = 1'b1;
        pulse_sw();
        wait_redir(3);
        check("R6", "nested entry", 32'(wr_cnt), 9);
        nest_en = 1'b0;
        @(negedge clk) resume = 1'b1;
        @(negedge clk) resume = 1'b0;
        idle(8);
        check("R7", "exit in_smm", 32'(in_smm), 0);
        check("R7", "exit real", 32'(real_mode), 0);
    endtask

    task automatic t_sw_gated();
        cfg_sw_mode = 1'b0;
        pulse_sw(); idle(8);
        check("R3", "pin mode", 32'(wr_cnt), 9);
        cfg_sw_mode = 1'b1; cfg_enable = 1'b0;
        pulse_sw(); idle(8);
        check("R3", "disabled", 32'(wr_cnt), 9);
        cfg_enable = 1'b1; cfg_region_size = 4'd0;
        pulse_sw(); idle(8);
        check("R3", "size zero", 32'(wr_cnt), 9);
        cfg_region_size = 4'd1;
        pulse_sw();
        wait_redir(4);
        check("R3", "accepted", 32'(wr_cnt), 12);
        check("R3", "in_smm", 32'(in_smm), 1);
    endtask

    initial begin
        idle(3);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        t_reset();
        t_stray_resume();
        t_pin_glitch();
        t_pin_gated();
        t_pin_entry();
        t_pending_resume();
        t_nest();
        t_sw_gated();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
            $finish;
        end
    end
endmodule